// File: doc/BRIEF.md
# Packed Normalized Float to 16-bit Converter

This block takes two IEEE single-precision operands and returns one 32-bit word that holds two 16-bit normalized integers. A single mode bit selects the conversion for both lanes together. In signed mode each operand is scaled by 32767. In unsigned mode each operand is scaled by 65535. Each scaled value is then rounded to the nearest integer, with exact halves going to the even neighbour, and saturated to the range of the mode.

The path is purely combinational. The result depends only on the current operands and the mode bit, so a caller can register it wherever its own pipeline needs a stage. NaN operands give zero. Infinities saturate like any other value that is out of range. The signed range is symmetric, so the code 0x8000 never appears.

Top module: `npk_pack_norm`

## Requirements
- R1: With modeSigned=1, a finite operand f gives the integer nearest to f*32767, written as a 16-bit two's complement value.
- R2: In signed mode a result above 32767 is clamped to 0x7FFF, and a result below -32767 is clamped to 0x8001. The code 0x8000 is never produced.
- R3: With modeSigned=0, a finite operand f gives the integer nearest to f*65535, written as a 16-bit unsigned value.
- R4: In unsigned mode a negative result becomes 0x0000, and a result above 65535 becomes 0xFFFF.
- R5: A NaN operand (exponent field all ones, non-zero fraction) gives 0x0000 in both modes.
- R6: +infinity gives the positive limit of the mode (0x7FFF or 0xFFFF). -infinity gives 0x8001 in signed mode and 0x0000 in unsigned mode.
- R7: The result for srcA occupies packedOut[15:0], and the result for srcB occupies packedOut[31:16].
- R8: The mode bit applies to both lanes in the same evaluation. The two lanes never use different scales.
- R9: When a scaled value lies exactly halfway between two integers, it rounds to the even one. For example, 0.5 gives 16384 in signed mode and 32768 in unsigned mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcA | input | 32 | First single-precision operand, placed in the low lane |
| srcB | input | 32 | Second single-precision operand, placed in the high lane |
| modeSigned | input | 1 | 1 selects signed scaling by 32767, 0 selects unsigned scaling by 65535 |
| packedOut | output | 32 | {srcB result, srcA result} |

## Verification
Rounding and saturation can both apply to the same lane. A value such as 1.0 scaled by the limit sits right at the clamp boundary, while slightly larger values round up past it. The bench drives ±1.0, ±2.0, infinities and exact half-way ties in the same word, so both lanes exercise different paths at once. Every result is judged against a real-number model that rounds and clamps on its own. Mixed words with a NaN in one lane and a tie or saturating value in the other show that the lanes stay independent while sharing one mode.

// File: rtl/npk_pkg.sv
package npk_pkg;
  parameter int LANE_W = 16;
  parameter int FP_W   = 32;
  parameter int EXP_W  = 8;
  parameter int MAN_W  = 23;
  parameter int BIAS   = 127;

  typedef struct packed {
    logic              isSigned;
    logic [LANE_W-1:0] scale;
    logic [LANE_W-1:0] posLimit;
  } ctrl_t;
endpackage

// File: rtl/npk_ctrl.sv
module npk_ctrl
  import npk_pkg::*;
(
  input  logic  modeSigned,
  output ctrl_t ctrlOut
);
  localparam logic [LANE_W-1:0] SGN_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] UNS_MAX = {LANE_W{1'b1}};

  always_comb begin
    ctrlOut.isSigned = modeSigned;
    ctrlOut.scale    = modeSigned ? SGN_MAX : UNS_MAX;
    ctrlOut.posLimit = modeSigned ? SGN_MAX : UNS_MAX;
  end
endmodule

// File: rtl/npk_lane.sv
module npk_lane
  import npk_pkg::*;
(
  input  logic [FP_W-1:0]   fpIn,
  input  ctrl_t             ctrl,
  output logic [LANE_W-1:0] laneOut
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = SIG_W + LANE_W;
  localparam int FRAC_W = PROD_W + 8;
  localparam int WIDE_W = PROD_W + FRAC_W;
  localparam int SH_W   = EXP_W + 1;
  localparam logic [SH_W-1:0] SH_BASE = SH_W'(BIAS + MAN_W);
  localparam logic [SH_W-1:0] SH_CAP  = SH_W'(FRAC_W);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_BIG  = EXP_W'(BIAS + 1);

  logic               sgn;
  logic [EXP_W-1:0]   expField;
  logic [MAN_W-1:0]   manField;
  logic               isNan, isBig;
  logic [SIG_W-1:0]   sig;
  logic [PROD_W-1:0]  prod;
  logic [SH_W-1:0]    rawSh, sh;
  logic [WIDE_W-1:0]  wide;
  logic [PROD_W-1:0]  intPart;
  logic               halfBit, stickyBit, roundUp;
  logic [PROD_W:0]    mag;
  logic               sat;
  logic [LANE_W-1:0]  magClamped;

  always_comb begin
    sgn      = fpIn[FP_W-1];
    expField = fpIn[FP_W-2 -: EXP_W];
    manField = fpIn[MAN_W-1:0];
    isNan    = (expField == EXP_ONES) && (manField != '0);
    isBig    = (expField >= EXP_BIG);
    sig      = {expField != '0, manField};
    prod     = PROD_W'(sig) * PROD_W'(ctrl.scale);
    rawSh    = SH_BASE - {1'b0, expField};
    sh       = (rawSh > SH_CAP) ? SH_CAP : rawSh;
    wide     = {prod, {FRAC_W{1'b0}}} >> sh;
    intPart  = wide[WIDE_W-1:FRAC_W];
    halfBit  = wide[FRAC_W-1];
    stickyBit = |wide[FRAC_W-2:0];
    roundUp  = halfBit && (stickyBit || intPart[0]);
    mag      = {1'b0, intPart} + (PROD_W+1)'(roundUp);
    sat      = isBig || (mag > (PROD_W+1)'(ctrl.posLimit));
    magClamped = sat ? ctrl.posLimit : mag[LANE_W-1:0];
    if (isNan)
      laneOut = '0;
    else if (ctrl.isSigned)
      laneOut = sgn ? (~magClamped + 1'b1) : magClamped;
    else
      laneOut = sgn ? '0 : magClamped;
  end

  always_comb begin
    if (isNan) AST_NAN_ZERO: assert (laneOut == '0); // R5
    if (ctrl.isSigned) AST_NO_MIN_NEG: assert (laneOut != {1'b1, {(LANE_W-1){1'b0}}}); // R2
    if (!ctrl.isSigned && sgn && !isNan) AST_UNS_NEG_ZERO: assert (laneOut == '0); // R4
    if (ctrl.isSigned && !isNan && laneOut != '0) AST_SIGN_MATCH: assert (laneOut[LANE_W-1] == sgn); // R1
    if (isBig && !isNan && !sgn) AST_INF_POS_LIMIT: assert (laneOut == ctrl.posLimit); // R6
  end
endmodule

// File: rtl/npk_pack_norm.sv
module npk_pack_norm
  import npk_pkg::*;
(
  input  logic [FP_W-1:0]     srcA,
  input  logic [FP_W-1:0]     srcB,
  input  logic                modeSigned,
  output logic [2*LANE_W-1:0] packedOut
);
  localparam int NUM_LANES = 2;

  ctrl_t             ctrlBus;
  logic [FP_W-1:0]   laneIn  [NUM_LANES];
  logic [LANE_W-1:0] laneRes [NUM_LANES];

  assign laneIn[0] = srcA;
  assign laneIn[1] = srcB;

  npk_ctrl i_ctrl (
    .modeSigned (modeSigned),
    .ctrlOut    (ctrlBus)
  );

  // R7: lane 0 (srcA) fills the low half and lane 1 (srcB) the high half; R8: one shared ctrl
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    npk_lane i_lane (
      .fpIn    (laneIn[g]),
      .ctrl    (ctrlBus),
      .laneOut (laneRes[g])
    );
    assign packedOut[g*LANE_W +: LANE_W] = laneRes[g];
  end
endmodule

// File: tb/test_npk_pack_norm.sv
module test_npk_pack_norm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcA = '0, srcB = '0;
  logic        modeSigned = 1'b0;
  logic [31:0] packedOut;

  int total = 0;
  int bad   = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  npk_pack_norm i_npk_pack_norm (
    .srcA(srcA), .srcB(srcB), .modeSigned(modeSigned), .packedOut(packedOut)
  );

  function automatic logic [15:0] refLane(input logic [31:0] b, input logic sm);
    real v, k, fl, d;
    longint n;
    int e;
    real m;
    if (b[30:23] == 8'hFF && b[22:0] != 0) return 16'h0000;
    k = sm ? 32767.0 : 65535.0;
    if (b[30:23] == 8'hFF) begin
      v = 1.0e6;
    end else begin
      m = real'(b[22:0]) + ((b[30:23] != 0) ? 8388608.0 : 0.0);
      e = (b[30:23] == 0) ? -149 : int'(b[30:23]) - 150;
      v = m * (2.0 ** e) * k;
      if (v > 1.0e5) v = 1.0e5;
    end
    if (b[31]) v = -v;
    fl = $floor(v);
    d  = v - fl;
    n  = longint'(fl);
    if (d > 0.5 || (d == 0.5 && n[0])) n++;
    if (sm) begin
      if (n > 32767) n = 32767;
      if (n < -32767) n = -32767;
    end else begin
      if (n < 0) n = 0;
      if (n > 65535) n = 65535;
    end
    return n[15:0];
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sm, input string tag);
    @(posedge clk);
    srcA = a; srcB = b; modeSigned = sm;
    expQ.push_back({refLane(b, sm), refLane(a, sm)});
    tagQ.push_back(tag);
  endtask

  // monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (packedOut !== e) begin
        bad++;
        $display("FAIL %s a=%h b=%h mode=%0d got=%h exp=%h", t, srcA, srcB, modeSigned, packedOut, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, 32'h0, 1'b0, "reset zero R3");
    drive(32'h3F800000, 32'hBF800000, 1'b1, "R1 R2 +-1.0");
    drive(32'hBF800000, 32'h3F800000, 1'b0, "R3 R4 R7 -1/+1");
    drive(32'h40000000, 32'hC0000000, 1'b1, "R2 +-2.0");
    drive(32'h40000000, 32'hC0000000, 1'b0, "R4 +-2.0");
    drive(32'h3F000000, 32'hBF000000, 1'b1, "R9 R1 tie 0.5");
    drive(32'h3F000000, 32'h3F000000, 1'b0, "R9 R3 tie 0.5");
    drive(32'h7FC00000, 32'h3F000000, 1'b1, "R5 nan low");
    drive(32'h3F800000, 32'hFFC00001, 1'b0, "R5 nan high");
    drive(32'h7F800000, 32'hFF800000, 1'b1, "R6 inf signed");
    drive(32'h7F800000, 32'hFF800000, 1'b0, "R6 inf unsigned");
    drive(32'h00000001, 32'h80000000, 1'b1, "R1 denorm -0");
    drive(32'h3E800000, 32'h3F400000, 1'b1, "R8 R1 mode both");
    drive(32'h3E800000, 32'h3F400000, 1'b0, "R8 R3 mode both");
    drive(32'h3F7FFFFF, 32'h3F800001, 1'b1, "R2 near one");
    drive(32'h3F7FFFFF, 32'h3F800001, 1'b0, "R4 near one");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 3 != 0) begin
        a[30:23] = 8'(108 + $urandom % 21);
        b[30:23] = 8'(108 + $urandom % 21);
      end
      drive(a, b, 1'(i % 2), (i % 2) ? "R1 R2 random" : "R3 R4 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule